// File: doc/BRIEF.md
# Flash Command Sequencer with Access-Error Checking

This block is the register-side controller of a small flash memory. Software starts an operation in three bus writes. First it writes a data word to an address inside the flash array. Next it writes a command code to the command register. Finally it writes the status register with bit 7 set, which launches the operation. The block checks every write against the order of that sequence. On any illegal step it sets an access-error flag, or a protection-violation flag for protected targets, and drops the half-built sequence.

A launch emits a one-cycle start pulse that carries the command, the address and the data. The flash array is replaced by a down-counter. Its command-complete flag returns a fixed number of clocks after the launch. While a command is running, one further burst-program sequence can be queued. Security gating and a special-mode-only margin command restrict which codes are accepted.

Register window: any address with bit ADDR_W-1 clear. Inside it, offset 0x0 is the clock divider, 0x2 the protection bound, 0x4 the status register and 0x6 the command register; other offsets are unmapped. Addresses with bit ADDR_W-1 set are array addresses. Register writes use bus_wdata[7:0].

Status byte: bit 7 buffer-empty, bit 6 command-complete, bit 5 protection-violation, bit 4 access-error, bits 3..0 zero. Defined command codes: 0x05 erase-verify, 0x20 program, 0x25 burst program, 0x40 sector erase, 0x41 mass erase, 0x75 margin setting. The program/erase group is 0x20, 0x25, 0x40 and 0x41. An array address is protected when its offset bits [ADDR_W-2:ADDR_W-9] are below the protection register value.

Top module: `flcmd_seq`

## Requirements
- R1: After reset the status byte reads 0xC0, with no error flags, the divider not loaded and the divider value 0.
- R2: An array write made before the divider register has been written since reset sets access-error (status bit 4) and starts no sequence.
- R3: An array write whose byte enables are not 2'b11, or whose address bit 0 is 1, sets access-error and starts no sequence.
- R4: Once an address is latched, a second array write, or a write to any register offset other than 0x6, sets access-error and aborts the sequence. A register write that aborts the sequence is itself not applied.
- R5: Once an address is latched, an undefined code written to the command register sets access-error and aborts the sequence. Code 0x75 counts as undefined when special_mode is 0. If the latched address is protected, protection-violation (bit 5) is set instead.
- R6: While a command runs (status bit 7 = 1 and bit 6 = 0), any defined command other than 0x25 sets access-error.
- R7: With sec_on = 1, a write where origin_secure = 0 or origin_debug = 1 is accepted only for command codes 0x05 and 0x41; any other code sets access-error.
- R8: Once a command is latched, an array write or a write to any register other than the status register sets access-error and aborts the sequence. A status write with bit 7 = 0 leaves the command latched.
- R9: A status write with bit 7 = 1 after a latched command launches it. In the following cycle arr_go is high for one cycle with the command, address and data. Bits 7 and 6 read 0 right after the launch edge. Bit 7 returns one edge later, and bit 6 returns exactly LAT_CYC edges after the launch edge.
- R10: In the status register, bits 4 and 5 are write-one-to-clear, each independently; writing 0 to a bit leaves it unchanged.
- R11: A program/erase command whose latched address is protected sets protection-violation and does not launch.
- R12: While bit 4 or bit 5 is set, array writes are ignored: no new sequence starts and no new error is raised.
- R13: With special_mode = 1, code 0x75 is accepted and launches like any other command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one transfer per cycle |
| bus_addr | input | ADDR_W (16) | Byte address |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_be | input | 2 | Byte enables |
| origin_secure | input | 1 | Write comes from a secure memory location |
| origin_debug | input | 1 | Write comes from the debug port |
| sec_on | input | 1 | Device security enabled |
| special_mode | input | 1 | Special operating mode |
| stat_q | output | 8 | Status byte |
| div_value | output | 8 | Clock-divider register value |
| arr_go | output | 1 | One-cycle launch pulse to the array |
| arr_cmd | output | 8 | Launched command code |
| arr_addr | output | ADDR_W (16) | Launched array address |
| arr_data | output | DATA_W (16) | Launched data word |

## Verification
The bench builds the block with LAT_CYC = 12, ADDR_W = 16 and DATA_W = 16. With a latency of twelve clocks, a complete second sequence fits inside the window where a command is still running, so both the rejection of non-burst codes and an accepted burst relaunch can be reached. Twelve clocks is still short enough that the exact completion edge can be checked cycle by cycle. Sixteen-bit addresses put the protection bound on offset bits 14..7, so a protection value of 4 covers array addresses 0x8000 to 0x81FF.

// File: rtl/flcmd_pkg.sv
package flcmd_pkg;

    localparam logic [7:0] CMD_ERASE_VFY = 8'h05;
    localparam logic [7:0] CMD_PROGRAM   = 8'h20;
    localparam logic [7:0] CMD_BURST     = 8'h25;
    localparam logic [7:0] CMD_SECT_ERS  = 8'h40;
    localparam logic [7:0] CMD_MASS_ERS  = 8'h41;
    localparam logic [7:0] CMD_MARGIN    = 8'h75;

    localparam logic [3:0] OFS_DIV  = 4'h0;
    localparam logic [3:0] OFS_PROT = 4'h2;
    localparam logic [3:0] OFS_STAT = 4'h4;
    localparam logic [3:0] OFS_CMD  = 4'h6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_CMD  = 2'd2
    } seq_state_t;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_DIV  = 3'd1,
        SEL_PROT = 3'd2,
        SEL_STAT = 3'd3,
        SEL_CMD  = 3'd4
    } reg_sel_t;

    typedef enum logic [1:0] {
        VD_OK  = 2'd0,
        VD_ACC = 2'd1,
        VD_PV  = 2'd2
    } verdict_t;

    typedef struct packed {
        logic buf_empty;
        logic done;
        logic pviol;
        logic accerr;
    } flags_t;

    function automatic logic cmd_defined(input logic [7:0] c, input logic special);
        case (c)
            CMD_ERASE_VFY, CMD_PROGRAM, CMD_BURST,
            CMD_SECT_ERS, CMD_MASS_ERS: cmd_defined = 1'b1;
            CMD_MARGIN:                 cmd_defined = special;
            default:                    cmd_defined = 1'b0;
        endcase
    endfunction

    function automatic logic cmd_modifies(input logic [7:0] c);
        cmd_modifies = (c == CMD_PROGRAM) || (c == CMD_BURST) ||
                       (c == CMD_SECT_ERS) || (c == CMD_MASS_ERS);
    endfunction

endpackage

// File: rtl/flcmd_decode.sv
module flcmd_decode
    import flcmd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        be,
    output logic              arr_hit,
    output logic              width_ok,
    output reg_sel_t          sel
);
    localparam int HI_W = ADDR_W - 5;

    logic in_window;

    always_comb begin
        arr_hit   = addr[ADDR_W-1];
        width_ok  = (be == 2'b11) && !addr[0];
        in_window = !addr[ADDR_W-1] && (addr[ADDR_W-2:4] == HI_W'(0));
        sel       = SEL_NONE;
        if (in_window) begin
            case (addr[3:0])
                OFS_DIV:  sel = SEL_DIV;
                OFS_PROT: sel = SEL_PROT;
                OFS_STAT: sel = SEL_STAT;
                OFS_CMD:  sel = SEL_CMD;
                default:  sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/flcmd_cmdcheck.sv
module flcmd_cmdcheck
    import flcmd_pkg::*;
(
    input  logic [7:0] code,
    input  logic       prot_hit,
    input  logic       running,
    input  logic       sec_on,
    input  logic       untrusted,
    input  logic       special_mode,
    output verdict_t   verdict
);
    always_comb begin
        if (!cmd_defined(code, special_mode))
            verdict = prot_hit ? VD_PV : VD_ACC;
        else if (running && code != CMD_BURST)
            verdict = VD_ACC;
        else if (sec_on && untrusted &&
                 code != CMD_ERASE_VFY && code != CMD_MASS_ERS)
            verdict = VD_ACC;
        else if (cmd_modifies(code) && prot_hit)
            verdict = VD_PV;
        else
            verdict = VD_OK;
    end
endmodule

// File: rtl/flcmd_timer.sv
module flcmd_timer #(
    parameter int LAT_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic fire
);
    localparam int CW = $clog2(LAT_CYC + 1);

    logic [CW-1:0] cnt;

    assign fire = (cnt == CW'(1)) && !load;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= CW'(LAT_CYC);
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end
endmodule

// File: rtl/flcmd_seq.sv
module flcmd_seq
    import flcmd_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int LAT_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [1:0]        bus_be,
    input  logic              origin_secure,
    input  logic              origin_debug,
    input  logic              sec_on,
    input  logic              special_mode,
    output logic [7:0]        stat_q,
    output logic [7:0]        div_value,
    output logic              arr_go,
    output logic [7:0]        arr_cmd,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_data
);
    localparam int PROT_LSB = ADDR_W - 9;

    seq_state_t        st_q;
    flags_t            fl_q;
    logic              div_ld;
    logic [7:0]        prot_q;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_data;
    logic [7:0]        lat_cmd;

    logic     arr_hit, width_ok, prot_hit, running, launch, fire;
    reg_sel_t sel;
    verdict_t verdict;

    flcmd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(bus_addr), .be(bus_be),
        .arr_hit(arr_hit), .width_ok(width_ok), .sel(sel)
    );

    assign prot_hit = lat_addr[ADDR_W-2:PROT_LSB] < prot_q;
    assign running  = fl_q.buf_empty && !fl_q.done;

    flcmd_cmdcheck u_chkcmd (
        .code(bus_wdata[7:0]), .prot_hit(prot_hit), .running(running),
        .sec_on(sec_on), .untrusted(!origin_secure || origin_debug),
        .special_mode(special_mode), .verdict(verdict)
    );

    assign launch = bus_wr && (st_q == ST_CMD) && (sel == SEL_STAT) && bus_wdata[7];

    flcmd_timer #(.LAT_CYC(LAT_CYC)) u_tmr (
        .clk(clk), .rst(rst), .load(launch), .fire(fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            fl_q      <= '{buf_empty: 1'b1, done: 1'b1, pviol: 1'b0, accerr: 1'b0};
            div_ld    <= 1'b0;
            div_value <= '0;
            prot_q    <= '0;
            lat_addr  <= '0;
            lat_data  <= '0;
            lat_cmd   <= '0;
            arr_go    <= 1'b0;
            arr_cmd   <= '0;
            arr_addr  <= '0;
            arr_data  <= '0;
        end else begin
            arr_go <= 1'b0;
            if (fire)            fl_q.done      <= 1'b1;
            if (!fl_q.buf_empty) fl_q.buf_empty <= 1'b1;
            if (bus_wr) begin
                case (st_q)
                    ST_IDLE: begin
                        if (arr_hit) begin
                            if (!fl_q.accerr && !fl_q.pviol) begin
                                if (!div_ld || !width_ok)
                                    fl_q.accerr <= 1'b1;
                                else begin
                                    lat_addr <= bus_addr;
                                    lat_data <= bus_wdata;
                                    st_q     <= ST_ADDR;
                                end
                            end
                        end else begin
                            case (sel)
                                SEL_DIV: begin
                                    div_value <= bus_wdata[7:0];
                                    div_ld    <= 1'b1;
                                end
                                SEL_PROT: prot_q <= bus_wdata[7:0];
                                SEL_STAT: begin
                                    if (bus_wdata[5]) fl_q.pviol  <= 1'b0;
                                    if (bus_wdata[4]) fl_q.accerr <= 1'b0;
                                end
                                default: ;
                            endcase
                        end
                    end
                    ST_ADDR: begin
                        if (!arr_hit && sel == SEL_CMD && verdict == VD_OK) begin
                            lat_cmd <= bus_wdata[7:0];
                            st_q    <= ST_CMD;
                        end else begin
                            if (!arr_hit && sel == SEL_CMD && verdict == VD_PV)
                                fl_q.pviol <= 1'b1;
                            else
                                fl_q.accerr <= 1'b1;
                            st_q     <= ST_IDLE;
                            lat_addr <= '0;
                            lat_data <= '0;
                        end
                    end
                    ST_CMD: begin
                        if (!arr_hit && sel == SEL_STAT) begin
                            if (launch) begin
                                fl_q.buf_empty <= 1'b0;
                                fl_q.done      <= 1'b0;
                                arr_go         <= 1'b1;
                                arr_cmd        <= lat_cmd;
                                arr_addr       <= lat_addr;
                                arr_data       <= lat_data;
                                st_q           <= ST_IDLE;
                            end
                        end else begin
                            fl_q.accerr <= 1'b1;
                            st_q        <= ST_IDLE;
                        end
                        if (launch || arr_hit || sel != SEL_STAT) begin
                            lat_addr <= '0;
                            lat_data <= '0;
                            lat_cmd  <= '0;
                        end
                    end
                    default: st_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign stat_q = {fl_q.buf_empty, fl_q.done, fl_q.pviol, fl_q.accerr, 4'b0000};

endmodule

// File: rtl/flcmd_seq_chk.sv
module flcmd_seq_chk
    import flcmd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       bus_wr,
    input logic       arr_hit,
    input logic       width_ok,
    input logic       div_ld,
    input seq_state_t st,
    input logic [7:0] stat,
    input logic       arr_go
);
    logic be_f, done_f, pv_f, acc_f;
    assign be_f   = stat[7];
    assign done_f = stat[6];
    assign pv_f   = stat[5];
    assign acc_f  = stat[4];

    a_r2_early_array_write: assert property (@(posedge clk) disable iff (rst)
        bus_wr && arr_hit && !div_ld && !acc_f && !pv_f && st == ST_IDLE |=> acc_f && st == ST_IDLE);

    a_r3_narrow_write: assert property (@(posedge clk) disable iff (rst)
        bus_wr && arr_hit && div_ld && !width_ok && !acc_f && !pv_f && st == ST_IDLE
        |=> acc_f && st == ST_IDLE);

    a_r4_second_address: assert property (@(posedge clk) disable iff (rst)
        bus_wr && arr_hit && st == ST_ADDR |=> acc_f && st == ST_IDLE);

    a_r8_address_after_cmd: assert property (@(posedge clk) disable iff (rst)
        bus_wr && arr_hit && st == ST_CMD |=> acc_f && st == ST_IDLE);

    a_r12_blocked_start: assert property (@(posedge clk) disable iff (rst)
        (acc_f || pv_f) && st == ST_IDLE |=> st == ST_IDLE);

    a_r9_go_clears_flags: assert property (@(posedge clk) disable iff (rst)
        arr_go |-> !done_f && !be_f);

    a_r9_done_implies_empty: assert property (@(posedge clk) disable iff (rst)
        done_f |-> be_f);

endmodule

bind flcmd_seq flcmd_seq_chk u_seq_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .arr_hit(arr_hit),
    .width_ok(width_ok), .div_ld(div_ld), .st(st_q), .stat(stat_q),
    .arr_go(arr_go)
);

// File: tb/test_flcmd_seq.sv
module test_flcmd_seq;
    localparam int CLK_PER = 10;
    localparam int LAT     = 12;

    localparam logic [15:0] A_DIV  = 16'h0000;
    localparam logic [15:0] A_PROT = 16'h0002;
    localparam logic [15:0] A_STAT = 16'h0004;
    localparam logic [15:0] A_CMD  = 16'h0006;

    logic        clk = 0, rst = 1;
    logic        bus_wr = 0;
    logic [15:0] bus_addr = 0, bus_wdata = 0;
    logic [1:0]  bus_be = 2'b11;
    logic        origin_secure = 1, origin_debug = 0, sec_on = 0, special_mode = 0;
    logic [7:0]  stat_q, div_value, arr_cmd;
    logic        arr_go;
    logic [15:0] arr_addr, arr_data;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [39:0] exp_q[$];

    always #(CLK_PER/2) clk = ~clk;

    flcmd_seq #(.ADDR_W(16), .DATA_W(16), .LAT_CYC(LAT)) i_flcmd_seq (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .origin_secure(origin_secure),
        .origin_debug(origin_debug), .sec_on(sec_on), .special_mode(special_mode),
        .stat_q(stat_q), .div_value(div_value), .arr_go(arr_go),
        .arr_cmd(arr_cmd), .arr_addr(arr_addr), .arr_data(arr_data)
    );

    task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d, input logic [1:0] be = 2'b11);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic expect_go(input logic [7:0] c, input logic [15:0] a, input logic [15:0] d);
        exp_q.push_back({c, a, d});
    endtask

    task automatic sequence_go(input logic [15:0] a, input logic [15:0] d, input logic [7:0] c);
        wr(a, d);
        wr(A_CMD, {8'h00, c});
        expect_go(c, a, d);
        wr(A_STAT, 16'h0080);
    endtask

    task automatic wait_done(input string tag);
        for (int i = 0; i < 100 && stat_q[6] == 1'b0; i++) @(negedge clk);
        chk(tag, stat_q, 8'hC0);
    endtask

    // scoreboard monitor: every launch pulse must match the oldest expected item
    always @(negedge clk) begin
        if (!rst && arr_go) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R9 unexpected launch actual=%h expected=none",
                         {arr_cmd, arr_addr, arr_data});
            end else begin
                chk("R9 launch contents", {arr_cmd, arr_addr, arr_data}, exp_q.pop_front());
            end
        end
    end

    initial begin
        for (int i = 0; i < 20000 && !finished; i++) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1 reset status", stat_q, 8'hC0);
        chk("R1 reset divider", div_value, 8'h00);

        wr(16'h8000, 16'h1111);
        chk("R2 array write before divider", stat_q, 8'hD0);
        wr(A_STAT, 16'h0030);
        chk("R10 clear flags", stat_q, 8'hC0);

        wr(A_DIV, 16'h0013);
        chk("R2 divider value", div_value, 8'h13);

        wr(16'h8002, 16'h2222, 2'b01);
        chk("R3 byte write", stat_q, 8'hD0);
        wr(A_STAT, 16'h0010);
        wr(16'h8003, 16'h2222);
        chk("R3 odd address", stat_q, 8'hD0);
        wr(A_STAT, 16'h0010);

        // R9 launch and exact latency
        sequence_go(16'h8100, 16'hABCD, 8'h20);
        chk("R9 flags after launch edge", stat_q, 8'h00);
        @(negedge clk);
        chk("R9 buffer empty one edge later", stat_q, 8'h80);
        repeat (LAT - 2) @(negedge clk);
        chk("R9 still running before latency", stat_q, 8'h80);
        @(negedge clk);
        chk("R9 complete at latency", stat_q, 8'hC0);

        // R4
        wr(16'h8200, 16'h3333);
        wr(A_DIV, 16'h0055);
        chk("R4 register write after address", stat_q, 8'hD0);
        chk("R4 aborting write not applied", div_value, 8'h13);
        wr(A_STAT, 16'h0010);
        wr(16'h8200, 16'h3333);
        wr(16'h8204, 16'h4444);
        chk("R4 second array write", stat_q, 8'hD0);
        wr(A_STAT, 16'h0010);
        wr(A_CMD, 16'h0020);
        wr(A_STAT, 16'h0080);
        chk("R4 aborted sequence discarded", stat_q, 8'hC0);

        // R5 / R13
        wr(16'h8200, 16'h0001);
        wr(A_CMD, 16'h0077);
        chk("R5 undefined code", stat_q, 8'hD0);
        wr(A_STAT, 16'h0010);
        wr(16'h8200, 16'h0001);
        wr(A_CMD, 16'h0075);
        chk("R5 margin code in normal mode", stat_q, 8'hD0);
        wr(A_STAT, 16'h0010);
        special_mode = 1;
        sequence_go(16'h8206, 16'h0002, 8'h75);
        wait_done("R13 margin code in special mode");
        special_mode = 0;

        wr(A_PROT, 16'h0004);
        wr(16'h8080, 16'h0003);
        wr(A_CMD, 16'h0077);
        chk("R5 undefined code at protected address", stat_q, 8'hE0);
        wr(A_STAT, 16'h0020);
        chk("R10 clear protection flag", stat_q, 8'hC0);

        // R11
        wr(16'h8080, 16'h0004);
        wr(A_CMD, 16'h0020);
        chk("R11 program into protected region", stat_q, 8'hE0);
        wr(A_STAT, 16'h0030);
        sequence_go(16'h8200, 16'h0005, 8'h40);
        wait_done("R11 erase just above bound");
        wr(A_PROT, 16'h0000);

        // R6
        sequence_go(16'h8300, 16'h0006, 8'h20);
        @(negedge clk);
        wr(16'h8302, 16'h0007);
        wr(A_CMD, 16'h0020);
        chk("R6 program while running", stat_q, 8'h90);
        wr(A_STAT, 16'h0010);
        sequence_go(16'h8304, 16'h0008, 8'h25);
        wait_done("R6 burst accepted while running");

        // R7
        sec_on = 1; origin_secure = 0;
        wr(16'h8400, 16'h0009);
        wr(A_CMD, 16'h0020);
        chk("R7 program from non-secure origin", stat_q, 8'hD0);
        wr(A_STAT, 16'h0010);
        sequence_go(16'h8400, 16'h000A, 8'h05);
        wait_done("R7 erase-verify from non-secure origin");
        origin_secure = 1; origin_debug = 1;
        sequence_go(16'h8402, 16'h000B, 8'h41);
        wait_done("R7 mass erase from debug origin");
        origin_debug = 0;
        sequence_go(16'h8404, 16'h000C, 8'h20);
        wait_done("R7 program from secure origin");
        sec_on = 0;

        // R8
        wr(16'h8500, 16'h000D);
        wr(A_CMD, 16'h0020);
        wr(16'h8502, 16'h000E);
        chk("R8 array write after command", stat_q, 8'hD0);
        wr(A_STAT, 16'h0010);
        wr(16'h8500, 16'h000D);
        wr(A_CMD, 16'h0020);
        wr(A_PROT, 16'h0001);
        chk("R8 register write after command", stat_q, 8'hD0);
        wr(A_STAT, 16'h0010);
        wr(16'h8600, 16'h000F);
        wr(A_CMD, 16'h0020);
        wr(A_STAT, 16'h0000);
        chk("R8 status write without launch bit", stat_q, 8'hC0);
        expect_go(8'h20, 16'h8600, 16'h000F);
        wr(A_STAT, 16'h0080);
        chk("R8 launch after plain status write", stat_q, 8'h00);
        wait_done("R8 completion");

        // R12 / R10
        wr(16'h8700, 16'h0010, 2'b10);
        wr(16'h8700, 16'h0010);
        chk("R12 array write ignored with error set", stat_q, 8'hD0);
        wr(A_STAT, 16'h0000);
        chk("R10 zero write keeps flag", stat_q, 8'hD0);
        wr(A_STAT, 16'h0020);
        chk("R10 other bit keeps flag", stat_q, 8'hD0);
        wr(A_STAT, 16'h0010);
        wr(A_CMD, 16'h0020);
        wr(A_STAT, 16'h0080);
        chk("R12 no sequence was started", stat_q, 8'hC0);

        repeat (3) @(negedge clk);
        chk("R9 all launches observed", 40'(exp_q.size()), 40'd0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule